// File: doc/BRIEF.md
# Assist-Path Severe Read Sequencer

This block is a test controller for a dual-port static memory whose write-assist circuit can pull the port-B bit-line low while port A is writing. It targets a broken discharge path inside that assist circuit. For every row in a programmed range it runs three stages. First, an ordinary port-A write of 0 puts the cell in a known state. Second, a port-A write of 1 runs with the port-A word-line kept closed. This write only charges the assist circuit's internal node high and leaves the cell unchanged. Third, the port-B word-line opens for a read of 0. Inside that read window, and before port-B sensing, the block inserts a port-A disturb: the port-A word-line stays closed, the assist enable is raised, and both port-A bit-lines are driven high.

A healthy assist path leaves the read value at 0. If the sensed value is 1, the row has the defect. The block uses only the existing word-line, bit-line drive, assist-enable and sense-enable timing signals. It adds no array hardware.

Two cycle counts are programmable: the offset from the port-B word-line opening to the start of the disturb, and the length of the disturb. The block sweeps rows in ascending order, keeps the first failing row, and reports start, busy, done and a sticky fail flag.

Top module: `severe_read_seq`

## Requirements
- R1: After reset, busy, done and fail are 0, and the outputs wlA, wlB, blDrvA, assistEn and saeB are all 0.
- R2: A start seen while idle makes busy 1 on the next cycle. That cycle is the init stage for row rowFirst: wlA=1, blDrvA=1, blA=0, blbA=1, wlB=0, assistEn=0, saeB=0.
- R3: The cycle after init is the charge stage: wlA=0, wlB=0, blDrvA=1, blA=1, blbA=0, assistEn=0, saeB=0. The cell is never opened during this stage.
- R4: The read-open stage follows and lasts exactly dstOffset cycles (none when dstOffset is 0). In it wlB=1, and wlA, blDrvA, assistEn and saeB are all 0.
- R5: The disturb stage then lasts dstLen cycles, or 1 cycle when dstLen is 0. In it wlB=1, wlA=0, assistEn=1, blDrvA=1, blA=1 and blbA=1, with saeB=0.
- R6: A single sense cycle follows the disturb, with wlB=1, saeB=1, assistEn=0, wlA=0 and blDrvA=0. saeB is never 1 outside this cycle, and senseData is ignored whenever saeB is 0.
- R7: A senseData value of 1 in a sense cycle sets fail from the next cycle on. failRow holds the row of the first such failure. Both stay until the next accepted start, which clears them.
- R8: Rows are visited in ascending order from rowFirst to rowLast, and rowAddr shows the current row throughout its stages. If rowFirst exceeds rowLast, only rowFirst is tested.
- R9: In the cycle after the sense of the last row, busy is 0 and done is 1. done stays 1 until the next accepted start. A start seen while busy has no effect.
- R10: rowFirst, rowLast, dstOffset and dstLen are captured at the accepted start. Changing them during a sweep has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| rowFirst | input | ADDR_W | First row of the sweep |
| rowLast | input | ADDR_W | Last row of the sweep |
| dstOffset | input | CNT_W | Cycles from port-B word-line opening to disturb start |
| dstLen | input | CNT_W | Disturb length in cycles (0 is treated as 1) |
| senseData | input | 1 | Port-B sense amplifier result, used only when saeB is 1 |
| rowAddr | output | ADDR_W | Row under test |
| wlA | output | 1 | Port-A word-line |
| wlB | output | 1 | Port-B word-line |
| blDrvA | output | 1 | Port-A bit-line driver enable |
| blA | output | 1 | Port-A true bit-line drive value |
| blbA | output | 1 | Port-A complement bit-line drive value |
| assistEn | output | 1 | Write-assist enable |
| saeB | output | 1 | Port-B sense-amplifier enable |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished (held until next start) |
| fail | output | 1 | Sticky defect flag |
| failRow | output | ADDR_W | First failing row |

## Verification
Sweeps are run with a non-zero offset and a multi-cycle disturb, with a zero offset and a one-cycle disturb, and with a zero length to check the one-cycle minimum. These runs separate the counting of each window from the fixed stages around it. Defective rows are injected at two points in one range to show that only the first is recorded. A clean sweep after a failing one shows that start clears the flag. A reversed range checks the single-row rule. senseData is held high outside the sense cycle to show it is ignored, and the inputs are changed, and start pulsed, mid-sweep to show that neither alters the running sequence.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_PRE   = 3'd2,
    ST_OPEN  = 3'd3,
    ST_DIST  = 3'd4,
    ST_SENSE = 3'd5
  } seqState_e;

  typedef struct packed {
    logic cellInit;
    logic preCharge;
    logic readOpen;
    logic disturb;
    logic sense;
    logic loadCfg;
    logic stepRow;
  } seqStrobe_t;

endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] offsetIn,
  input  logic [CNT_W-1:0] lenIn,
  input  logic             isLast,
  output seqStrobe_t       strb,
  output logic             busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seqState_e        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [CNT_W-1:0] offReg, lenReg;
  logic             accept;

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_IDLE:  if (accept) stateNxt = ST_INIT;
      ST_INIT:  stateNxt = ST_PRE;
      ST_PRE: begin
        cntNxt   = '0;
        stateNxt = (offReg == '0) ? ST_DIST : ST_OPEN;
      end
      ST_OPEN: begin
        if (cnt == offReg - ONE) begin
          cntNxt   = '0;
          stateNxt = ST_DIST;
        end else begin
          cntNxt = cnt + ONE;
        end
      end
      ST_DIST: begin
        if (cnt == lenReg - ONE) begin
          cntNxt   = '0;
          stateNxt = ST_SENSE;
        end else begin
          cntNxt = cnt + ONE;
        end
      end
      ST_SENSE: stateNxt = isLast ? ST_IDLE : ST_INIT;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      offReg <= '0;
      lenReg <= ONE;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (accept) begin
        offReg <= offsetIn;
        lenReg <= (lenIn == '0) ? ONE : lenIn;
      end
    end
  end

  always_comb begin
    strb.cellInit  = (state == ST_INIT);
    strb.preCharge = (state == ST_PRE);
    strb.readOpen  = (state == ST_OPEN);
    strb.disturb   = (state == ST_DIST);
    strb.sense     = (state == ST_SENSE);
    strb.loadCfg   = accept;
    strb.stepRow   = (state == ST_SENSE) && !isLast;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/srs_dpath.sv
module srs_dpath
  import srs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] firstIn,
  input  logic [ADDR_W-1:0] lastIn,
  input  logic              senseData,
  output logic              isLast,
  output logic [ADDR_W-1:0] rowAddr,
  output logic              wlA,
  output logic              wlB,
  output logic              blDrvA,
  output logic              blA,
  output logic              blbA,
  output logic              assistEn,
  output logic              saeB,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failRow
);

  logic [ADDR_W-1:0] row, lastReg;

  assign isLast = (row >= lastReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row     <= '0;
      lastReg <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      failRow <= '0;
    end else if (strb.loadCfg) begin
      row     <= firstIn;
      lastReg <= lastIn;
      done    <= 1'b0;
      fail    <= 1'b0;
      failRow <= '0;
    end else begin
      if (strb.stepRow) row <= row + ADDR_W'(1);
      if (strb.sense && isLast) done <= 1'b1;
      if (strb.sense && senseData && !fail) begin
        fail    <= 1'b1;
        failRow <= row;
      end
    end
  end

  assign rowAddr  = row;
  assign wlA      = strb.cellInit;
  assign wlB      = strb.readOpen | strb.disturb | strb.sense;
  assign blDrvA   = strb.cellInit | strb.preCharge | strb.disturb;
  assign blA      = strb.preCharge | strb.disturb;
  assign blbA     = strb.cellInit | strb.disturb;
  assign assistEn = strb.disturb;
  assign saeB     = strb.sense;

endmodule

// File: rtl/severe_read_seq.sv
module severe_read_seq
  import srs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] rowFirst,
  input  logic [ADDR_W-1:0] rowLast,
  input  logic [CNT_W-1:0]  dstOffset,
  input  logic [CNT_W-1:0]  dstLen,
  input  logic              senseData,
  output logic [ADDR_W-1:0] rowAddr,
  output logic              wlA,
  output logic              wlB,
  output logic              blDrvA,
  output logic              blA,
  output logic              blbA,
  output logic              assistEn,
  output logic              saeB,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failRow
);

  seqStrobe_t strb;
  logic       isLast;

  srs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .offsetIn(dstOffset), .lenIn(dstLen), .isLast(isLast),
    .strb(strb), .busy(busy)
  );

  srs_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .firstIn(rowFirst), .lastIn(rowLast), .senseData(senseData),
    .isLast(isLast), .rowAddr(rowAddr), .wlA(wlA), .wlB(wlB),
    .blDrvA(blDrvA), .blA(blA), .blbA(blbA), .assistEn(assistEn),
    .saeB(saeB), .done(done), .fail(fail), .failRow(failRow)
  );

endmodule

// File: rtl/srs_checker.sv
module srs_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic wlA,
  input logic wlB,
  input logic blDrvA,
  input logic blA,
  input logic blbA,
  input logic assistEn,
  input logic saeB,
  input logic busy,
  input logic done,
  input logic fail
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wlA && !wlB && !assistEn && !saeB && !blDrvA)); // R1

  AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    wlA |-> !wlB); // R2

  AST_CHARGE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (blDrvA && blA && !blbA) |-> (!wlA && !wlB)); // R3

  AST_DIST_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    assistEn |-> (wlB && !wlA && blDrvA && blA && blbA && !saeB)); // R5

  AST_SENSE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    saeB |-> (wlB && !wlA && !assistEn && !blDrvA)); // R6

  AST_SENSE_AFTER_DIST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saeB) |-> $past(assistEn)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

endmodule

bind severe_read_seq srs_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .wlA(wlA), .wlB(wlB),
  .blDrvA(blDrvA), .blA(blA), .blbA(blbA), .assistEn(assistEn),
  .saeB(saeB), .busy(busy), .done(done), .fail(fail)
);

// File: tb/severe_read_seq_tb.sv
`timescale 1ns/1ps
module severe_read_seq_tb;

  localparam int AW = 6;
  localparam int CW = 8;

  typedef struct packed {
    logic [2:0]    stg;
    logic          wlA, wlB, drv, blA, blbA, asst, sae;
    logic [AW-1:0] row;
  } expVec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] rowFirst = '0, rowLast = '0;
  logic [CW-1:0] dstOffset = '0, dstLen = '0;
  logic senseData;
  logic [AW-1:0] rowAddr, failRow;
  logic wlA, wlB, blDrvA, blA, blbA, assistEn, saeB, busy, done, fail;

  logic [63:0] badMask = '0;
  logic noise = 1'b0;
  int checks = 0;
  int errors = 0;
  logic expFail = 1'b0;
  logic [AW-1:0] expFailRow = '0;

  assign senseData = saeB ? badMask[rowAddr] : noise;

  always #2 clk = ~clk;

  severe_read_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rowFirst(rowFirst),
    .rowLast(rowLast), .dstOffset(dstOffset), .dstLen(dstLen),
    .senseData(senseData), .rowAddr(rowAddr), .wlA(wlA), .wlB(wlB),
    .blDrvA(blDrvA), .blA(blA), .blbA(blbA), .assistEn(assistEn),
    .saeB(saeB), .busy(busy), .done(done), .fail(fail), .failRow(failRow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string stgReq(logic [2:0] s);
    case (s)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic expVec_t mk(logic [2:0] s, int r);
    expVec_t v;
    v.stg = s; v.row = AW'(r);
    v.wlA = (s == 3'd1);
    v.wlB = (s >= 3'd3);
    v.drv = (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    v.blA = (s == 3'd2) || (s == 3'd4);
    v.blbA = (s == 3'd1) || (s == 3'd4);
    v.asst = (s == 3'd4);
    v.sae = (s == 3'd5);
    return v;
  endfunction

  // Runs one sweep; midStart pulses start while busy, scramble changes inputs (R9, R10)
  task automatic sweep(int first, int last, int off, int len, bit midStart, bit scramble);
    expVec_t q[$];
    expVec_t v;
    int lenEff;
    int step;
    lenEff = (len == 0) ? 1 : len;
    for (int r = first; ; r++) begin
      q.push_back(mk(3'd1, r));
      q.push_back(mk(3'd2, r));
      for (int i = 0; i < off; i++) q.push_back(mk(3'd3, r));
      for (int i = 0; i < lenEff; i++) q.push_back(mk(3'd4, r));
      q.push_back(mk(3'd5, r));
      if (r >= last) break;
    end
    @(negedge clk);
    rowFirst = AW'(first); rowLast = AW'(last);
    dstOffset = CW'(off); dstLen = CW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expFail = 1'b0; expFailRow = '0;
    if (scramble) begin
      rowFirst = AW'(first + 3); rowLast = AW'(last + 5);
      dstOffset = CW'(off + 4); dstLen = CW'(len + 2);
    end
    step = 0;
    while (q.size() > 0) begin
      v = q.pop_front();
      chk(stgReq(v.stg), {wlA, wlB, blDrvA, blA, blbA, assistEn, saeB},
          {v.wlA, v.wlB, v.drv, v.blA, v.blbA, v.asst, v.sae});
      chk("R8 rowAddr", 32'(rowAddr), 32'(v.row));
      chk("R9 busy", 32'({busy, done}), 32'(2'b10));
      chk("R7 fail", 32'({fail, failRow}), 32'({expFail, expFailRow}));
      if (v.sae && badMask[v.row] && !expFail) begin
        expFail = 1'b1; expFailRow = v.row;
      end
      start = (midStart && step == 3);
      step++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9 done", 32'({busy, done}), 32'(2'b01));
    chk("R7 final", 32'({fail, failRow}), 32'({expFail, expFailRow}));
    repeat (2) @(negedge clk);
    chk("R9 hold", 32'({busy, done}), 32'(2'b01));
    chk("R7 hold", 32'({fail, failRow}), 32'({expFail, expFailRow}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 32'({busy, done, fail, wlA, wlB, blDrvA, assistEn, saeB}), 32'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after", 32'({busy, done, fail, wlA, wlB, blDrvA, assistEn, saeB}), 32'(0));
    // R4 R5: offset 2, length 3, clean rows
    sweep(2, 5, 2, 3, 1'b0, 1'b0);
    // R7: two bad rows, first recorded; zero offset
    badMask = '0; badMask[1] = 1'b1; badMask[3] = 1'b1;
    sweep(0, 3, 0, 1, 1'b0, 1'b0);
    // R6: noise outside sense ignored; R5 zero length; R9 start while busy
    badMask = '0; noise = 1'b1;
    sweep(7, 8, 1, 0, 1'b1, 1'b0);
    noise = 1'b0;
    // R8 reversed range, R10 inputs changed mid sweep
    badMask = '0; badMask[9] = 1'b1;
    sweep(9, 4, 3, 2, 1'b0, 1'b1);
    // R7 start clears fail on clean sweep
    badMask = '0;
    sweep(60, 63, 1, 2, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule